// File: doc/BRIEF.md
# I2C Master Register and FIFO Front End

This block is the memory-mapped face of an I2C master controller. Software programs the target address, the number of data bytes, the direction and the clock divider words through a 32-bit register bus. It loads transmit bytes into one FIFO and drains received bytes from another, then sets the start bit. A separate byte-level bus engine produces the SCL/SDA waveforms. It pulls transmit bytes from this block, pushes received bytes into it, and reports the end of the transfer together with an acknowledge result.

The block keeps a busy flag for the whole transfer. It raises a sticky pending flag when a transfer ends, and also when either FIFO crosses its programmed level while that level's interrupt is enabled. The pending flag drives the interrupt line through a global enable. Software clears the sticky flags by writing zero to them. A separate register lets software flush both FIFOs at once. A suppress-stop bit in the control register lets a write be followed by a repeated start.

Top module: `i2cm_regfront`

## Requirements
- R1: After synchronous reset every register reads zero except status, which reads only the transmit-empty bit (bit 3) and the live line levels. The interrupt output is low and the stop request is high.
- R2: The control register (offset 0x00) keeps only bits 0..3, 9, 10 and 12..20, and all other bits read zero. The address register (0x04) keeps only bits 7:1, and those bits go to the engine as the 7-bit target address. The count register (0x08) keeps its low 16 bits. The divider words (0x20, 0x24) and the start-hold count (0x28) keep all 32 bits.
- R3: The engine's stop request is the inverse of control bit 20. The engine's read direction follows control bit 3 (1 = read).
- R4: A control write with bit 0 (start) and bit 2 (enable) both at 1, made while the stored start bit is 0, sets busy (status bit 0) and the engine go output on the next cycle. A start written without enable sets nothing. A done pulse from the engine clears busy. The start bit itself stays 1 until software writes it to 0.
- R5: Each write to 0x10 appends its low byte to a 16-entry transmit FIFO. The engine receives the bytes in order, one per pop request. A write to a full transmit FIFO is dropped.
- R6: Each engine receive strobe appends a byte to a 16-entry receive FIFO, and a strobe into a full FIFO is dropped. Each read of 0x0C returns the oldest byte and removes it. A read of an empty receive FIFO returns 0 and changes nothing.
- R7: Writing 1 to bit 0 of 0x2C empties both FIFOs. A receive strobe in the same cycle is discarded.
- R8: Status bit 3 shows an empty transmit FIFO and bit 4 a full receive FIFO. Bits 20 and 21 show the live SCL and SDA inputs.
- R9: A done pulse sets pending (status bit 2). If the engine's NACK input is high with that pulse, NACK (status bit 1) is set as well.
- R10: Pending is set when the transmit level is at or below control bits 15:12 while bit 9 is 1. It is also set when the receive level is at or above control bits 19:16 while bit 10 is 1.
- R11: A status write clears pending or NACK where the written bit is 0 and leaves it alone where the written bit is 1. A set event in the same cycle wins over the clear.
- R12: The interrupt output is high exactly when pending is 1 and control bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Interrupt request |
| eng_go | output | 1 | Transfer in progress, to the engine |
| eng_read | output | 1 | Transfer direction, 1 = read |
| eng_stop | output | 1 | Issue stop at the end of the transfer |
| eng_addr | output | 7 | Target address |
| eng_count | output | 16 | Data byte count |
| eng_tx_avail | output | 1 | Transmit FIFO holds a byte |
| eng_tx_byte | output | 8 | Oldest transmit byte |
| eng_tx_req | input | 1 | Pop one transmit byte |
| eng_rx_valid | input | 1 | Push eng_rx_byte into the receive FIFO |
| eng_rx_byte | input | 8 | Received byte |
| eng_done | input | 1 | Transfer finished (one-cycle pulse) |
| eng_nack | input | 1 | No acknowledge seen, qualifies eng_done |
| scl_in | input | 1 | Live SCL level |
| sda_in | input | 1 | Live SDA level |
| div_lo | output | 32 | Divider low word |
| div_hi | output | 32 | Divider high word |
| hold_cnt | output | 32 | Start-hold count |

## Verification
The clash that matters is a status write that clears pending in the same cycle as an engine done pulse that sets it. The bench drives the write-zero and the done pulse on the same clock edge. It then expects pending, and so the interrupt with the global enable on, to remain set. A second clash is a flush in the same cycle as a receive strobe. It is provoked the same way and judged by reading 0 from the receive data register and seeing the status empty and full bits afterwards.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int REG_AW = 6;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 6'h00;
    localparam logic [REG_AW-1:0] OFS_SADDR = 6'h04;
    localparam logic [REG_AW-1:0] OFS_COUNT = 6'h08;
    localparam logic [REG_AW-1:0] OFS_RXD   = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_TXD   = 6'h10;
    localparam logic [REG_AW-1:0] OFS_STAT  = 6'h14;
    localparam logic [REG_AW-1:0] OFS_DIVLO = 6'h20;
    localparam logic [REG_AW-1:0] OFS_DIVHI = 6'h24;
    localparam logic [REG_AW-1:0] OFS_HOLD  = 6'h28;
    localparam logic [REG_AW-1:0] OFS_FLUSH = 6'h2C;

    // status bit positions
    localparam int ST_BUSY  = 0;
    localparam int ST_NACK  = 1;
    localparam int ST_PEND  = 2;
    localparam int ST_TXEMP = 3;
    localparam int ST_RXFUL = 4;
    localparam int ST_SCL   = 20;
    localparam int ST_SDA   = 21;

    typedef struct packed {
        logic       no_stop;   // bit 20
        logic [3:0] af_lvl;    // bits 19:16
        logic [3:0] ae_lvl;    // bits 15:12
        logic       full_ie;   // bit 10
        logic       empty_ie;  // bit 9
        logic       dir_rd;    // bit 3
        logic       en;        // bit 2
        logic       gie;       // bit 1
        logic       start;     // bit 0
    } ctrl_t;

    typedef struct packed {
        logic busy;
        logic nack;
        logic pend;
    } flags_t;

    function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
        ctrl_t c;
        c.no_stop  = w[20];
        c.af_lvl   = w[19:16];
        c.ae_lvl   = w[15:12];
        c.full_ie  = w[10];
        c.empty_ie = w[9];
        c.dir_rd   = w[3];
        c.en       = w[2];
        c.gie      = w[1];
        c.start    = w[0];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        logic [31:0] w;
        w        = '0;
        w[20]    = c.no_stop;
        w[19:16] = c.af_lvl;
        w[15:12] = c.ae_lvl;
        w[10]    = c.full_ie;
        w[9]     = c.empty_ie;
        w[3]     = c.dir_rd;
        w[2]     = c.en;
        w[1]     = c.gie;
        w[0]     = c.start;
        return w;
    endfunction

endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] level,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/i2cm_flags.sv
module i2cm_flags
    import i2cm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_evt,
    input  logic   done,
    input  logic   nack_in,
    input  logic   thr_hit,
    input  logic   stat_wr,
    input  logic   keep_nack,
    input  logic   keep_pend,
    output flags_t flags
);
    flags_t nxt;

    always_comb begin
        nxt = flags;
        if (start_evt)     nxt.busy = 1'b1;
        else if (done)     nxt.busy = 1'b0;

        if (done && nack_in)            nxt.nack = 1'b1;
        else if (stat_wr && !keep_nack) nxt.nack = 1'b0;

        if (done || thr_hit)            nxt.pend = 1'b1;
        else if (stat_wr && !keep_pend) nxt.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= nxt;
    end

endmodule

// File: rtl/i2cm_regfront.sv
module i2cm_regfront
    import i2cm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              eng_go,
    output logic              eng_read,
    output logic              eng_stop,
    output logic [6:0]        eng_addr,
    output logic [CNT_W-1:0]  eng_count,
    output logic              eng_tx_avail,
    output logic [7:0]        eng_tx_byte,
    input  logic              eng_tx_req,
    input  logic              eng_rx_valid,
    input  logic [7:0]        eng_rx_byte,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic [31:0]       div_lo,
    output logic [31:0]       div_hi,
    output logic [31:0]       hold_cnt
);
    ctrl_t            ctrl;
    logic [6:0]       taddr;
    logic [CNT_W-1:0] count;
    flags_t           flg;

    logic wr_ctrl, wr_stat, wr_txd, wr_flush, rd_rxd;
    logic start_evt, thr_hit;

    logic [7:0]    rx_dout;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_empty, tx_full, rx_empty, rx_full;

    assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_stat  = reg_wr && (reg_addr == OFS_STAT);
    assign wr_txd   = reg_wr && (reg_addr == OFS_TXD);
    assign wr_flush = reg_wr && (reg_addr == OFS_FLUSH) && reg_wdata[0];
    assign rd_rxd   = reg_rd && (reg_addr == OFS_RXD);

    // a new transfer begins on a 0->1 start write with the enable bit on
    assign start_evt = wr_ctrl && reg_wdata[0] && reg_wdata[2] && !ctrl.start;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            taddr    <= '0;
            count    <= '0;
            div_lo   <= '0;
            div_hi   <= '0;
            hold_cnt <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_CTRL:  ctrl     <= ctrl_from_word(reg_wdata);
                OFS_SADDR: taddr    <= reg_wdata[7:1];
                OFS_COUNT: count    <= reg_wdata[CNT_W-1:0];
                OFS_DIVLO: div_lo   <= reg_wdata;
                OFS_DIVHI: div_hi   <= reg_wdata;
                OFS_HOLD:  hold_cnt <= reg_wdata;
                default:   ;
            endcase
        end
    end

    i2cm_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .flush (wr_flush),
        .push  (wr_txd),
        .din   (reg_wdata[7:0]),
        .pop   (eng_tx_req),
        .dout  (eng_tx_byte),
        .level (tx_cnt),
        .empty (tx_empty),
        .full  (tx_full)
    );

    i2cm_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .flush (wr_flush),
        .push  (eng_rx_valid),
        .din   (eng_rx_byte),
        .pop   (rd_rxd),
        .dout  (rx_dout),
        .level (rx_cnt),
        .empty (rx_empty),
        .full  (rx_full)
    );

    assign thr_hit = (ctrl.empty_ie && (tx_cnt <= CW'(ctrl.ae_lvl))) ||
                     (ctrl.full_ie  && (rx_cnt >= CW'(ctrl.af_lvl)));

    i2cm_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .start_evt (start_evt),
        .done      (eng_done),
        .nack_in   (eng_nack),
        .thr_hit   (thr_hit),
        .stat_wr   (wr_stat),
        .keep_nack (reg_wdata[ST_NACK]),
        .keep_pend (reg_wdata[ST_PEND]),
        .flags     (flg)
    );

    assign irq          = flg.pend && ctrl.gie;
    assign eng_go       = flg.busy;
    assign eng_read     = ctrl.dir_rd;
    assign eng_stop     = !ctrl.no_stop;
    assign eng_addr     = taddr;
    assign eng_count    = count;
    assign eng_tx_avail = !tx_empty;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL:  reg_rdata = ctrl_to_word(ctrl);
            OFS_SADDR: reg_rdata[7:1] = taddr;
            OFS_COUNT: reg_rdata[CNT_W-1:0] = count;
            OFS_RXD:   reg_rdata[7:0] = rx_empty ? 8'h00 : rx_dout;
            OFS_STAT: begin
                reg_rdata[ST_BUSY]  = flg.busy;
                reg_rdata[ST_NACK]  = flg.nack;
                reg_rdata[ST_PEND]  = flg.pend;
                reg_rdata[ST_TXEMP] = tx_empty;
                reg_rdata[ST_RXFUL] = rx_full;
                reg_rdata[ST_SCL]   = scl_in;
                reg_rdata[ST_SDA]   = sda_in;
            end
            OFS_DIVLO: reg_rdata = div_lo;
            OFS_DIVHI: reg_rdata = div_hi;
            OFS_HOLD:  reg_rdata = hold_cnt;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2cm_regfront_chk.sv
module i2cm_regfront_chk
    import i2cm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              eng_done,
    input logic              eng_tx_req,
    input logic              start_evt,
    input logic              busy,
    input logic              pend,
    input logic [CW-1:0]     tx_cnt,
    input logic              tx_empty,
    input logic              rx_empty
);
    // R4
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> busy);

    // R4
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        eng_done && !start_evt |=> !busy);

    // R9
    done_pend_chk: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> pend);

    // R6
    rx_empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd && (reg_addr == OFS_RXD) && rx_empty |-> (reg_rdata == 32'h0));

    // R5
    tx_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr && (reg_addr == OFS_TXD) && (tx_cnt == CW'(DEPTH)) && !eng_tx_req
        |=> (tx_cnt == CW'(DEPTH)));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr && (reg_addr == OFS_FLUSH) && reg_wdata[0] |=> tx_empty && rx_empty);

endmodule

bind i2cm_regfront i2cm_regfront_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .eng_done   (eng_done),
    .eng_tx_req (eng_tx_req),
    .start_evt  (start_evt),
    .busy       (flg.busy),
    .pend       (flg.pend),
    .tx_cnt     (tx_cnt),
    .tx_empty   (tx_empty),
    .rx_empty   (rx_empty)
);

// File: tb/tb_i2cm_regfront.sv
module tb_i2cm_regfront;
    import i2cm_pkg::*;

    localparam int DEPTH = 16;
    localparam logic [31:0] CTRL_KEEP = 32'h001F_F60F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, eng_go, eng_read, eng_stop, eng_tx_avail;
    logic [6:0]  eng_addr;
    logic [15:0] eng_count;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_req = 1'b0, eng_rx_valid = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        eng_done = 1'b0, eng_nack = 1'b0;
    logic        scl_in = 1'b1, sda_in = 1'b1;
    logic [31:0] div_lo, div_hi, hold_cnt;

    int vecs = 0;
    int bad  = 0;

    always #10 clk = ~clk;

    i2cm_regfront dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .eng_go(eng_go),
        .eng_read(eng_read), .eng_stop(eng_stop), .eng_addr(eng_addr),
        .eng_count(eng_count), .eng_tx_avail(eng_tx_avail), .eng_tx_byte(eng_tx_byte),
        .eng_tx_req(eng_tx_req), .eng_rx_valid(eng_rx_valid), .eng_rx_byte(eng_rx_byte),
        .eng_done(eng_done), .eng_nack(eng_nack), .scl_in(scl_in), .sda_in(sda_in),
        .div_lo(div_lo), .div_hi(div_hi), .hold_cnt(hold_cnt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic done_pulse(input logic nk);
        @(negedge clk);
        eng_done = 1'b1; eng_nack = nk;
        @(negedge clk);
        eng_done = 1'b0; eng_nack = 1'b0;
    endtask

    task automatic pop_tx(output logic av, output logic [7:0] b);
        @(negedge clk);
        av = eng_tx_avail; b = eng_tx_byte; eng_tx_req = 1'b1;
        @(negedge clk);
        eng_tx_req = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] b);
        @(negedge clk);
        eng_rx_valid = 1'b1; eng_rx_byte = b;
        @(negedge clk);
        eng_rx_valid = 1'b0;
    endtask

    function automatic logic [31:0] stat_word(input logic busy, nk, pend, txe, rxf);
        logic [31:0] s;
        s = '0;
        s[0] = busy; s[1] = nk; s[2] = pend; s[3] = txe; s[4] = rxf;
        s[20] = scl_in; s[21] = sda_in;
        return s;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, d;
        logic        av;
        logic [7:0]  b;
        logic [7:0]  model [$];
        int          n;

        v = $urandom(32'd7719);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(OFS_CTRL, v);  check("R1 ctrl", v, 32'h0);
        rd(OFS_SADDR, v); check("R1 addr", v, 32'h0);
        rd(OFS_STAT, v);  check("R1 status", v, stat_word(0, 0, 0, 1, 0));
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 stop", {31'b0, eng_stop}, 32'h1);

        // R2 random register readback
        for (int i = 0; i < 20; i++) begin
            d = $urandom() & ~32'h1;
            wr(OFS_CTRL, d);
            rd(OFS_CTRL, v); check("R2 ctrl mask", v, d & CTRL_KEEP);
            check("R3 stop", {31'b0, eng_stop}, {31'b0, ~d[20]});
            check("R3 dir", {31'b0, eng_read}, {31'b0, d[3]});
            d = $urandom();
            wr(OFS_SADDR, d);
            rd(OFS_SADDR, v); check("R2 addr", v, d & 32'hFE);
            check("R2 eng_addr", {25'b0, eng_addr}, {25'b0, d[7:1]});
            d = $urandom();
            wr(OFS_COUNT, d);
            rd(OFS_COUNT, v); check("R2 count", v, d & 32'hFFFF);
            d = $urandom(); wr(OFS_DIVLO, d); rd(OFS_DIVLO, v); check("R2 divlo", v, d);
            d = $urandom(); wr(OFS_DIVHI, d); rd(OFS_DIVHI, v); check("R2 divhi", v, d);
            d = $urandom(); wr(OFS_HOLD, d);  rd(OFS_HOLD, v);  check("R2 hold", v, d);
        end
        wr(OFS_CTRL, 32'h0);
        wr(OFS_STAT, 32'h0);

        // R8 live lines
        scl_in = 1'b0; sda_in = 1'b1;
        rd(OFS_STAT, v); check("R8 lines", v, stat_word(0, 0, 0, 1, 0));
        scl_in = 1'b1; sda_in = 1'b0;
        rd(OFS_STAT, v); check("R8 lines", v, stat_word(0, 0, 0, 1, 0));
        sda_in = 1'b1;

        // R4 start without enable does nothing
        wr(OFS_CTRL, 32'h1);
        check("R4 no enable", {31'b0, eng_go}, 32'h0);
        wr(OFS_CTRL, 32'h0);

        // R4 start with enable, R9 done, R12 gating
        wr(OFS_CTRL, 32'h5);
        check("R4 go", {31'b0, eng_go}, 32'h1);
        rd(OFS_STAT, v); check("R4 busy", v, stat_word(1, 0, 0, 1, 0));
        done_pulse(1'b0);
        rd(OFS_STAT, v); check("R9 done", v, stat_word(0, 0, 1, 1, 0));
        rd(OFS_CTRL, v); check("R4 start held", v, 32'h5);
        check("R12 irq masked", {31'b0, irq}, 32'h0);
        wr(OFS_CTRL, 32'h7);
        check("R12 irq on", {31'b0, irq}, 32'h1);
        wr(OFS_STAT, 32'h0);
        check("R11 clear", {31'b0, irq}, 32'h0);

        // R9 nack, R11 write-one keeps
        done_pulse(1'b1);
        rd(OFS_STAT, v); check("R9 nack", v, stat_word(0, 1, 1, 1, 0));
        wr(OFS_STAT, 32'h2);
        rd(OFS_STAT, v); check("R11 keep nack", v, stat_word(0, 1, 0, 1, 0));
        wr(OFS_STAT, 32'h0);
        rd(OFS_STAT, v); check("R11 clear nack", v, stat_word(0, 0, 0, 1, 0));

        // R11 clear and done in the same cycle: set wins
        @(negedge clk);
        reg_addr = OFS_STAT; reg_wdata = 32'h0; reg_wr = 1'b1; eng_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; eng_done = 1'b0;
        check("R11 set wins", {31'b0, irq}, 32'h1);
        wr(OFS_CTRL, 32'h0);
        wr(OFS_STAT, 32'h0);

        // R5 transmit FIFO with random fills, one overfilled
        for (int r = 0; r < 4; r++) begin
            n = (r == 0) ? 20 : int'($urandom_range(1, 16));
            model.delete();
            for (int i = 0; i < n; i++) begin
                d = $urandom();
                wr(OFS_TXD, d);
                if (model.size() < DEPTH) model.push_back(d[7:0]);
            end
            foreach (model[i]) begin
                pop_tx(av, b);
                check("R5 avail", {31'b0, av}, 32'h1);
                check("R5 order", {24'b0, b}, {24'b0, model[i]});
            end
            check("R5 drained", {31'b0, eng_tx_avail}, 32'h0);
        end

        // R6 receive FIFO, full flag, empty read
        for (int r = 0; r < 3; r++) begin
            n = (r == 0) ? 18 : int'($urandom_range(1, 16));
            model.delete();
            for (int i = 0; i < n; i++) begin
                b = 8'($urandom());
                push_rx(b);
                if (model.size() < DEPTH) model.push_back(b);
            end
            rd(OFS_STAT, v);
            check("R8 rx full", {31'b0, v[4]}, {31'b0, model.size() == DEPTH});
            foreach (model[i]) begin
                rd(OFS_RXD, v);
                check("R6 order", v, {24'b0, model[i]});
            end
            rd(OFS_RXD, v); check("R6 empty read", v, 32'h0);
        end

        // R7 flush with a receive strobe in the same cycle
        for (int i = 0; i < 3; i++) begin wr(OFS_TXD, 32'hA0 + i); push_rx(8'h50 + 8'(i)); end
        @(negedge clk);
        reg_addr = OFS_FLUSH; reg_wdata = 32'h1; reg_wr = 1'b1;
        eng_rx_valid = 1'b1; eng_rx_byte = 8'hEE;
        @(negedge clk);
        reg_wr = 1'b0; eng_rx_valid = 1'b0;
        check("R7 tx flushed", {31'b0, eng_tx_avail}, 32'h0);
        rd(OFS_RXD, v); check("R7 rx flushed", v, 32'h0);
        rd(OFS_STAT, v); check("R7 status", v, stat_word(0, 0, 0, 1, 0));

        // R10 transmit almost-empty level 2
        for (int i = 0; i < 5; i++) wr(OFS_TXD, 32'h10 + i);
        wr(OFS_CTRL, (32'd2 << 12) | (32'd1 << 9));
        rd(OFS_STAT, v); check("R10 above ae", {31'b0, v[2]}, 32'h0);
        pop_tx(av, b); pop_tx(av, b);
        @(negedge clk);
        rd(OFS_STAT, v); check("R10 tx at 3", {31'b0, v[2]}, 32'h0);
        pop_tx(av, b);
        @(negedge clk);
        rd(OFS_STAT, v); check("R10 tx at 2", {31'b0, v[2]}, 32'h1);
        wr(OFS_CTRL, 32'h0);
        wr(OFS_FLUSH, 32'h1);
        wr(OFS_STAT, 32'h0);

        // R10 receive almost-full level 3
        wr(OFS_CTRL, (32'd3 << 16) | (32'd1 << 10));
        push_rx(8'h01); push_rx(8'h02);
        @(negedge clk);
        rd(OFS_STAT, v); check("R10 rx at 2", {31'b0, v[2]}, 32'h0);
        push_rx(8'h03);
        @(negedge clk);
        rd(OFS_STAT, v); check("R10 rx at 3", {31'b0, v[2]}, 32'h1);

        $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule